// File: doc/BRIEF.md
# Dual-View Register Bank

This block is the peripheral register bank of a small 8-bit processor. One register can be reached at two addresses. The short I/O-port view uses a 6-bit address and serves the dedicated in/out operations. The data-space view uses an 8-bit address and serves ordinary load/store operations. Every I/O-port location also appears in the data space, shifted up by a fixed offset of 0x20. An extended window at data-space 0x60 and above exists only in the data view.

A third port carries single-bit operations: set, clear and test. These work only on the lowest 32 I/O addresses, and each touches nothing but the named bit. The bank holds the following:

- three general-purpose storage registers;
- one plain register above the bit window;
- one extended register;
- a status register whose flags are raised by hardware event inputs and cleared by writing ones.

All other locations are reserved. Reads return zero and writes change nothing.

Top module: `dual_view_regbank`

## Requirements
- R1: The I/O-port view uses a 6-bit address. A write with `io_we` high updates the addressed register at the next rising edge. `io_rdata` returns the addressed register combinationally.
- R2: I/O location A is reachable through the data view at A + 0x20, for reads and for writes. Examples: general registers at data 0x2C–0x2E, status at data 0x25, high register at data 0x4A.
- R3: The extended register sits at data address 0x90. It is reachable only through the data view. Other addresses in data 0x60–0xFF are reserved.
- R4: The following locations are reserved: unmapped I/O addresses and data addresses 0x00–0x1F. Reads from them return 0x00, and writes to them leave every register unchanged.
- R5: The general registers sit at I/O 0x0C, 0x0D and 0x0E and provide plain read/write storage. A bit set forces bit `bit_idx` to 1 and a bit clear forces it to 0. Both leave every other bit unchanged.
- R6: Bit operations at I/O addresses 0x20–0x3F are ignored. There, `bit_val` reads 0 and the high register at I/O 0x2A keeps its value.
- R7: `bit_val` reports bit `bit_idx` of the register at `bit_addr` within the same cycle.
- R8: The status register sits at I/O 0x05. Writing it clears each flag whose written bit is 1 and keeps each flag whose written bit is 0. Hardware raises flag i when `flag_set[i]` is 1.
- R9: A bit set on the status register clears only the named flag. A bit clear on it has no effect.
- R10: A hardware flag-set event wins over a software clear of the same flag in the same cycle.
- R11: Several writes may reach one register in the same cycle. The I/O-port write wins over the data-view write, and the data-view write wins over a bit operation.
- R12: A synchronous reset clears every register and flag to zero, and it overrides hardware flag-set events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 6 | I/O-port view address |
| io_we | input | 1 | I/O-port write strobe |
| io_wdata | input | 8 | I/O-port write data |
| io_rdata | output | 8 | I/O-port read data |
| ds_addr | input | 8 | Data-view address |
| ds_we | input | 1 | Data-view write strobe |
| ds_wdata | input | 8 | Data-view write data |
| ds_rdata | output | 8 | Data-view read data |
| bit_addr | input | 6 | I/O address for bit operations |
| bit_idx | input | 3 | Bit position for bit operations |
| bit_set | input | 1 | Bit-set request |
| bit_clr | input | 1 | Bit-clear request |
| bit_val | output | 1 | Value of the selected bit |
| flag_set | input | 8 | Hardware event inputs that raise status flags |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. One is a hardware event landing in the cycle of a software clear of the same flag. The other is three write sources reaching one register together. Directed steps drive `flag_set` in the same falling-edge slot as an I/O write or a bit set, and drive all three write paths into one general register at once. Each result is read back through the I/O view. Before the collisions, a vector table walks both views, the alias offset, the reserved holes and the edge of the bit window.

// File: rtl/dvrb_pkg.sv
package dvrb_pkg;
   // Behaviour variant of one storage cell
   typedef enum logic [0:0] {
      CELL_PLAIN = 1'b0,   // read/write storage
      CELL_W1C   = 1'b1    // flags: hardware sets, software ones clear
   } cell_kind_e;
endpackage

// File: rtl/dvrb_ds_map.sv
// Translates a data-view address into the I/O view or the extended window.
module dvrb_ds_map #(
   parameter int IO_AW     = 6,
   parameter int DS_AW     = 8,
   parameter int OFFSET    = 'h20,
   parameter int EXT_BASE  = 'h60
) (
   input  logic [DS_AW-1:0] ds_addr,
   output logic             in_io,
   output logic [IO_AW-1:0] io_idx,
   output logic             in_ext
);
   localparam int SPAN = 1 << IO_AW;

   logic [DS_AW-1:0] diff;

   always_comb begin
      diff   = ds_addr - DS_AW'(OFFSET);
      in_io  = (ds_addr >= DS_AW'(OFFSET)) && (diff < DS_AW'(SPAN));
      io_idx = diff[IO_AW-1:0];
      in_ext = ds_addr >= DS_AW'(EXT_BASE);
   end
endmodule

// File: rtl/dvrb_cell.sv
// One register with a word-write port, a single-bit write port and
// hardware set inputs; KIND selects plain or write-one-to-clear behaviour.
module dvrb_cell
   import dvrb_pkg::*;
#(
   parameter int         DW   = 8,
   parameter cell_kind_e KIND = CELL_PLAIN
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic [DW-1:0]         wr_data,
   input  logic                  bit_wr,
   input  logic                  bit_v,
   input  logic [$clog2(DW)-1:0] bit_idx,
   input  logic [DW-1:0]         hw_set,
   output logic [DW-1:0]         q
);
   logic [DW-1:0] nxt;

   generate
      if (KIND == CELL_W1C) begin : g_w1c
         always_comb begin
            nxt = q;
            if (wr_en)
               nxt = q & ~wr_data;
            else if (bit_wr && bit_v)
               nxt[bit_idx] = 1'b0;
            nxt = nxt | hw_set;
         end
      end else begin : g_plain
         always_comb begin
            nxt = q;
            if (wr_en)
               nxt = wr_data;
            else if (bit_wr)
               nxt[bit_idx] = bit_v;
            nxt = nxt | hw_set;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
   end
endmodule

// File: rtl/dual_view_regbank.sv
module dual_view_regbank
   import dvrb_pkg::*;
#(
   parameter int DW        = 8,
   parameter int IO_AW     = 6,
   parameter int DS_AW     = 8,
   parameter int DS_OFFSET = 'h20,
   parameter int BIT_WIN   = 'h20,
   parameter int EXT_BASE  = 'h60,
   parameter int NUM_GP    = 3,
   parameter int GP_BASE   = 'h0C,
   parameter int FLAG_ADDR = 'h05,
   parameter int HI_ADDR   = 'h2A,
   parameter int EXT_ADDR  = 'h90
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [IO_AW-1:0]      io_addr,
   input  logic                  io_we,
   input  logic [DW-1:0]         io_wdata,
   output logic [DW-1:0]         io_rdata,
   input  logic [DS_AW-1:0]      ds_addr,
   input  logic                  ds_we,
   input  logic [DW-1:0]         ds_wdata,
   output logic [DW-1:0]         ds_rdata,
   input  logic [IO_AW-1:0]      bit_addr,
   input  logic [$clog2(DW)-1:0] bit_idx,
   input  logic                  bit_set,
   input  logic                  bit_clr,
   output logic                  bit_val,
   input  logic [DW-1:0]         flag_set
);
   localparam int IO_SPAN = 1 << IO_AW;
   localparam int DS_SPAN = 1 << DS_AW;
   localparam int NIO     = NUM_GP + 2;   // status, general registers, high register

   // Elaboration-time parameter checks
   generate
      if (GP_BASE + NUM_GP > BIT_WIN || FLAG_ADDR >= BIT_WIN)
         $error("general and status registers must lie inside the bit window");
      if (FLAG_ADDR >= GP_BASE && FLAG_ADDR < GP_BASE + NUM_GP)
         $error("status register overlaps general registers");
      if (HI_ADDR < BIT_WIN || HI_ADDR >= IO_SPAN || BIT_WIN > IO_SPAN)
         $error("high register must lie above the bit window in the I/O view");
      if (DS_OFFSET + IO_SPAN > EXT_BASE || EXT_ADDR < EXT_BASE || EXT_ADDR >= DS_SPAN)
         $error("data-view windows overlap or exceed the data address space");
   endgenerate

   // I/O address of slot k: slot 0 status, then general registers, then high register
   function automatic logic [IO_AW-1:0] slot_addr(input int k);
      if (k == 0)           return IO_AW'(FLAG_ADDR);
      else if (k <= NUM_GP) return IO_AW'(GP_BASE + k - 1);
      else                  return IO_AW'(HI_ADDR);
   endfunction

   logic             ds_in_io, ds_in_ext;
   logic [IO_AW-1:0] ds_idx;
   logic             bit_in_win;
   logic [DW-1:0]    slot_q [NIO];
   logic [DW-1:0]    ext_q;

   dvrb_ds_map #(
      .IO_AW(IO_AW), .DS_AW(DS_AW), .OFFSET(DS_OFFSET), .EXT_BASE(EXT_BASE)
   ) map_i (
      .ds_addr(ds_addr), .in_io(ds_in_io), .io_idx(ds_idx), .in_ext(ds_in_ext)
   );

   assign bit_in_win = bit_addr < IO_AW'(BIT_WIN);

   generate
      for (genvar k = 0; k < NIO; k++) begin : g_slot
         logic          io_hit, ds_hit, b_hit;
         logic [DW-1:0] wd;
         always_comb begin
            io_hit = io_we && (io_addr == slot_addr(k));
            ds_hit = ds_we && ds_in_io && (ds_idx == slot_addr(k));
            b_hit  = (bit_set || bit_clr) && bit_in_win && (bit_addr == slot_addr(k));
            wd     = io_hit ? io_wdata : ds_wdata;
         end
         dvrb_cell #(
            .DW(DW), .KIND((k == 0) ? CELL_W1C : CELL_PLAIN)
         ) cell_i (
            .clk(clk), .rst(rst),
            .wr_en(io_hit || ds_hit), .wr_data(wd),
            .bit_wr(b_hit), .bit_v(bit_set), .bit_idx(bit_idx),
            .hw_set((k == 0) ? flag_set : '0),
            .q(slot_q[k])
         );
      end
   endgenerate

   dvrb_cell #(.DW(DW), .KIND(CELL_PLAIN)) ext_i (
      .clk(clk), .rst(rst),
      .wr_en(ds_we && ds_in_ext && (ds_addr == DS_AW'(EXT_ADDR))),
      .wr_data(ds_wdata),
      .bit_wr(1'b0), .bit_v(1'b0), .bit_idx('0),
      .hw_set('0),
      .q(ext_q)
   );

   // Read paths
   logic [DW-1:0] bit_word;

   always_comb begin
      io_rdata = '0;
      ds_rdata = '0;
      bit_word = '0;
      for (int k = 0; k < NIO; k++) begin
         if (io_addr == slot_addr(k))
            io_rdata = slot_q[k];
         if (ds_in_io && ds_idx == slot_addr(k))
            ds_rdata = slot_q[k];
         if (bit_in_win && bit_addr == slot_addr(k))
            bit_word = slot_q[k];
      end
      if (ds_in_ext && ds_addr == DS_AW'(EXT_ADDR))
         ds_rdata = ext_q;
      bit_val = bit_word[bit_idx];
   end
endmodule

// File: rtl/dvrb_chk.sv
module dvrb_chk #(
   parameter int DW        = 8,
   parameter int IO_AW     = 6,
   parameter int DS_AW     = 8,
   parameter int DS_OFFSET = 'h20,
   parameter int BIT_WIN   = 'h20,
   parameter int NUM_GP    = 3,
   parameter int GP_BASE   = 'h0C,
   parameter int FLAG_ADDR = 'h05,
   parameter int HI_ADDR   = 'h2A
) (
   input logic             clk,
   input logic             rst,
   input logic [IO_AW-1:0] io_addr,
   input logic             io_we,
   input logic [DW-1:0]    io_rdata,
   input logic [DS_AW-1:0] ds_addr,
   input logic             ds_we,
   input logic [DW-1:0]    ds_rdata,
   input logic [IO_AW-1:0] bit_addr,
   input logic             bit_set,
   input logic             bit_clr,
   input logic             bit_val,
   input logic [DW-1:0]    flag_set,
   input logic [DW-1:0]    flag_q,
   input logic [DW-1:0]    hi_q,
   input logic [DW-1:0]    ext_q
);
   logic io_known;
   assign io_known = (io_addr == IO_AW'(FLAG_ADDR)) || (io_addr == IO_AW'(HI_ADDR)) ||
                     (io_addr >= IO_AW'(GP_BASE) && io_addr < IO_AW'(GP_BASE + NUM_GP));

   a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
      (|flag_set) |=> ((flag_q & $past(flag_set)) == $past(flag_set)));

   a_r2_alias: assert property (@(posedge clk) disable iff (rst)
      (ds_addr == DS_AW'(io_addr) + DS_AW'(DS_OFFSET)) |-> (ds_rdata == io_rdata));

   a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      !io_known |-> (io_rdata == '0));

   a_r6_outside_window: assert property (@(posedge clk) disable iff (rst)
      (bit_addr >= IO_AW'(BIT_WIN)) |-> !bit_val);

   a_r6_hi_untouched: assert property (@(posedge clk) disable iff (rst)
      ((bit_set || bit_clr) && !io_we && !ds_we) |=> $stable(hi_q));

   a_r3_ext_data_only: assert property (@(posedge clk) disable iff (rst)
      !ds_we |=> $stable(ext_q));

   a_r12_reset_clears: assert property (@(posedge clk)
      rst |=> (flag_q == '0 && hi_q == '0 && ext_q == '0));
endmodule

bind dual_view_regbank dvrb_chk #(
   .DW(DW), .IO_AW(IO_AW), .DS_AW(DS_AW), .DS_OFFSET(DS_OFFSET), .BIT_WIN(BIT_WIN),
   .NUM_GP(NUM_GP), .GP_BASE(GP_BASE), .FLAG_ADDR(FLAG_ADDR), .HI_ADDR(HI_ADDR)
) chk_i (
   .clk(clk), .rst(rst),
   .io_addr(io_addr), .io_we(io_we), .io_rdata(io_rdata),
   .ds_addr(ds_addr), .ds_we(ds_we), .ds_rdata(ds_rdata),
   .bit_addr(bit_addr), .bit_set(bit_set), .bit_clr(bit_clr), .bit_val(bit_val),
   .flag_set(flag_set),
   .flag_q(slot_q[0]), .hi_q(slot_q[NUM_GP+1]), .ext_q(ext_q)
);

// File: tb/dual_view_regbank_tb.sv
module dual_view_regbank_tb_top;
   logic       clk = 1'b0;
   logic       rst;
   logic [5:0] io_addr;
   logic       io_we;
   logic [7:0] io_wdata, io_rdata;
   logic [7:0] ds_addr;
   logic       ds_we;
   logic [7:0] ds_wdata, ds_rdata;
   logic [5:0] bit_addr;
   logic [2:0] bit_idx;
   logic       bit_set, bit_clr, bit_val;
   logic [7:0] flag_set;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   dual_view_regbank dut_i (
      .clk(clk), .rst(rst),
      .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
      .bit_addr(bit_addr), .bit_idx(bit_idx), .bit_set(bit_set), .bit_clr(bit_clr),
      .bit_val(bit_val), .flag_set(flag_set)
   );

   // Vector: {req, op, addr, data, expected}
   // op: 0 io write, 1 io read, 2 data write, 3 data read, 4 bit set, 5 bit clear, 6 bit test
   localparam int NV = 28;
   localparam logic [39:0] VEC [NV] = '{
      40'h01_00_0C_A5_00,   // R1 write general register
      40'h01_01_0C_00_A5,   // R1 read back
      40'h02_03_2C_00_A5,   // R2 same register via data view
      40'h02_02_2D_3C_00,   // R2 data-view write
      40'h02_01_0D_00_3C,   // R2 seen through I/O view
      40'h03_02_90_77_00,   // R3 extended register write
      40'h03_03_90_00_77,   // R3 extended read
      40'h03_02_91_11_00,   // R3 neighbour of extended register is reserved
      40'h03_03_91_00_00,   // R3
      40'h04_00_10_FF_00,   // R4 reserved I/O write
      40'h04_01_10_00_00,   // R4 reads zero
      40'h04_02_05_FF_00,   // R4 data 0x05 unmapped, must not hit status
      40'h04_03_05_00_00,   // R4
      40'h04_01_05_00_00,   // R4 status unchanged
      40'h05_04_0E_03_00,   // R5 set bit 3
      40'h05_01_0E_00_08,   // R5
      40'h05_04_0E_07_00,   // R5 set bit 7
      40'h05_05_0E_03_00,   // R5 clear bit 3
      40'h05_01_0E_00_80,   // R5
      40'h07_06_0E_07_01,   // R7 test set bit
      40'h07_06_0E_00_00,   // R7 test clear bit
      40'h06_00_2A_F0_00,   // R6 high register write
      40'h06_05_2A_04_00,   // R6 bit clear outside window ignored
      40'h06_04_2A_01_00,   // R6 bit set outside window ignored
      40'h06_01_2A_00_F0,   // R6
      40'h06_06_2A_04_00,   // R6 test outside window reads 0
      40'h02_03_4A_00_F0,   // R2 high register alias
      40'h01_01_0C_00_A5    // R1 untouched by the rest
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic idle();
      io_we = 1'b0; ds_we = 1'b0; bit_set = 1'b0; bit_clr = 1'b0; flag_set = 8'h00;
   endtask

   task automatic io_wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk); idle(); io_addr = a; io_wdata = d; io_we = 1'b1;
   endtask

   task automatic ds_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); idle(); ds_addr = a; ds_wdata = d; ds_we = 1'b1;
   endtask

   task automatic io_chk(input string req, input logic [5:0] a, input logic [7:0] e);
      @(negedge clk); idle(); io_addr = a; #1; chk(req, io_rdata, e);
   endtask

   task automatic ds_chk(input string req, input logic [7:0] a, input logic [7:0] e);
      @(negedge clk); idle(); ds_addr = a; #1; chk(req, ds_rdata, e);
   endtask

   task automatic reset_and_check();
      @(negedge clk); idle(); rst = 1'b1; flag_set = 8'hFF;
      repeat (2) @(negedge clk);
      rst = 1'b0; flag_set = 8'h00;
      io_chk("R12 status", 6'h05, 8'h00);
      io_chk("R12 gp0", 6'h0C, 8'h00);
      io_chk("R12 gp1", 6'h0D, 8'h00);
      io_chk("R12 gp2", 6'h0E, 8'h00);
      io_chk("R12 high", 6'h2A, 8'h00);
      ds_chk("R12 extended", 8'h90, 8'h00);
   endtask

   initial begin
      idle();
      rst = 1'b1; io_addr = '0; io_wdata = '0; ds_addr = '0; ds_wdata = '0;
      bit_addr = '0; bit_idx = '0;
      reset_and_check();

      // Table walk
      for (int i = 0; i < NV; i++) begin
         logic [7:0] rq, op, ad, dt, ex;
         {rq, op, ad, dt, ex} = VEC[i];
         @(negedge clk); idle();
         case (op)
            8'd0: begin io_addr = ad[5:0]; io_wdata = dt; io_we = 1'b1; end
            8'd1: io_addr = ad[5:0];
            8'd2: begin ds_addr = ad; ds_wdata = dt; ds_we = 1'b1; end
            8'd3: ds_addr = ad;
            8'd4: begin bit_addr = ad[5:0]; bit_idx = dt[2:0]; bit_set = 1'b1; end
            8'd5: begin bit_addr = ad[5:0]; bit_idx = dt[2:0]; bit_clr = 1'b1; end
            default: begin bit_addr = ad[5:0]; bit_idx = dt[2:0]; end
         endcase
         #1;
         case (op)
            8'd1: chk($sformatf("R%0d vector %0d", rq, i), io_rdata, ex);
            8'd3: chk($sformatf("R%0d vector %0d", rq, i), ds_rdata, ex);
            8'd6: chk($sformatf("R%0d vector %0d", rq, i), {7'd0, bit_val}, ex);
            default: ;
         endcase
      end

      // R8: hardware raises flags, write-one-to-clear
      @(negedge clk); idle(); flag_set = 8'hFF;
      io_chk("R8 flags raised", 6'h05, 8'hFF);
      io_wr(6'h05, 8'h0F);
      io_chk("R8 ones clear", 6'h05, 8'hF0);
      io_wr(6'h05, 8'h00);
      io_chk("R8 zeros keep", 6'h05, 8'hF0);

      // R9: bit set clears one flag, bit clear does nothing
      @(negedge clk); idle(); bit_addr = 6'h05; bit_idx = 3'd4; bit_set = 1'b1;
      io_chk("R9 bit set clears one flag", 6'h05, 8'hE0);
      @(negedge clk); idle(); bit_addr = 6'h05; bit_idx = 3'd5; bit_clr = 1'b1;
      io_chk("R9 bit clear no effect", 6'h05, 8'hE0);

      // R10: set wins over same-cycle clear
      @(negedge clk); idle(); flag_set = 8'h80; io_addr = 6'h05; io_wdata = 8'h80; io_we = 1'b1;
      io_chk("R10 set beats write clear", 6'h05, 8'hE0);
      ds_wr(8'h25, 8'h20);
      io_chk("R8 clear via data view", 6'h05, 8'hC0);
      @(negedge clk); idle(); flag_set = 8'h01; bit_addr = 6'h05; bit_idx = 3'd0; bit_set = 1'b1;
      io_chk("R10 set beats bit clear", 6'h05, 8'hC1);

      // R11: write priority
      @(negedge clk); idle();
      io_addr = 6'h0C; io_wdata = 8'h11; io_we = 1'b1;
      ds_addr = 8'h2C; ds_wdata = 8'h22; ds_we = 1'b1;
      bit_addr = 6'h0C; bit_idx = 3'd7; bit_set = 1'b1;
      io_chk("R11 io write wins", 6'h0C, 8'h11);
      @(negedge clk); idle();
      ds_addr = 8'h2C; ds_wdata = 8'h22; ds_we = 1'b1;
      bit_addr = 6'h0C; bit_idx = 3'd0; bit_set = 1'b1;
      io_chk("R11 data write beats bit op", 6'h0C, 8'h22);

      // R12: reset overrides events
      reset_and_check();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL all requirements: watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule